// File: doc/BRIEF.md
# Register Block with Read and Write Access Strobes

This block holds two 8-bit fields behind a one-cycle CPU request port. The status field, at address 0, can only be read by software. Hardware supplies its current value on a dedicated input, and a read samples that input directly. The control field, at address 1, can be read and written by software and drives its stored value to hardware. It resets to 20.

Each field can raise four single-cycle strobes toward the hardware side:
- an access strobe on any software access;
- a modify strobe on writes, and on reads when the read has a side effect;
- a strobe that fires on reads only;
- a strobe that fires on writes only.

Each strobe is switched on by its own parameter, and every switch defaults to off. A disabled strobe is held at 0.

A request is taken in the cycle `req_vld` is high, and the strobes fire in that same cycle. On the next clock edge the read data is captured and the control field takes written data. One cycle after the request, an acknowledge appears: `rd_ack` for a read, `wr_ack` for a write. `rsp_rdata` is valid while `rd_ack` is high.

A small state machine sequences the response. Its states are:
- `S_IDLE`: no response is pending.
- `S_RACK`: a read acknowledge is being returned.
- `S_WACK`: a write acknowledge is being returned.

Its transitions are:
- Any state goes to `S_RACK` when a read request arrives.
- Any state goes to `S_WACK` when a write request arrives.
- Any state goes to `S_IDLE` when no request arrives or reset is high.

A parameter can make reads of the control field clear it to zero. That read counts as a modifying access.

Top module: `strobe_regblk`

## Requirements
- R1: While `rst` is high and in the first cycle after it drops, `ctl_value` is 20, both acknowledges are 0, and every strobe is 0.
- R2: A request taken in cycle N produces an acknowledge in cycle N+1 only. A read gives `rd_ack`=1 and `wr_ack`=0. A write gives `wr_ack`=1 and `rd_ack`=0.
- R3: A read at address 0 returns in `rsp_rdata` the `stat_next` value present in the request cycle. When enabled, `stat_rd_acc` is 1 in exactly that cycle and 0 in the next one.
- R4: A write at address 1 raises `ctl_wr_acc` (when enabled) in the request cycle, while `ctl_value` still shows the old value. In the next cycle `ctl_value` equals the written data and the strobe is back at 0.
- R5: Read strobes never fire on a write, and write strobes never fire on a read.
- R6: When enabled, a field's access strobe is 1 in the request cycle of every read or write that hits that field.
- R7: When enabled, `ctl_mod` fires on every write to the control field. It also fires on a read of that field, but only when the read-clear option is set.
- R8: With the read-clear option set, a read of address 1 returns the stored value, and in the following cycle `ctl_value` is 0.
- R9: A request to any address other than 0 or 1 is acknowledged. A read there returns 0, and no strobe of either field fires.
- R10: A write to address 0 raises no strobe and changes nothing. A later read at address 0 still returns `stat_next`.
- R11: Every strobe whose enable parameter is left at its default of off stays 0 through reads and writes of its field.
- R12: A read at address 1 returns the current `ctl_value`. Without read-clear, it raises `ctl_rd_acc` and `ctl_acc` but not `ctl_mod`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | Request valid for one cycle |
| req_wr | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW (4) | Request address |
| req_wdata | input | DW (8) | Write data |
| rd_ack | output | 1 | Read acknowledge, one cycle after the request |
| wr_ack | output | 1 | Write acknowledge, one cycle after the request |
| rsp_rdata | output | DW (8) | Read data, valid with `rd_ack` |
| stat_next | input | DW (8) | Hardware-supplied value of the status field |
| stat_acc | output | 1 | Status field: any-access strobe |
| stat_mod | output | 1 | Status field: modify strobe |
| stat_rd_acc | output | 1 | Status field: read strobe |
| stat_wr_acc | output | 1 | Status field: write strobe |
| ctl_value | output | DW (8) | Stored value of the control field |
| ctl_acc | output | 1 | Control field: any-access strobe |
| ctl_mod | output | 1 | Control field: modify strobe |
| ctl_rd_acc | output | 1 | Control field: read strobe |
| ctl_wr_acc | output | 1 | Control field: write strobe |

## Verification
The properties assume that a request lasts exactly one cycle and that `req_wr`, `req_addr`, `req_wdata` and `stat_next` are steady for that whole cycle. This matters because strobes are combinational from the request, while data and stored values are sampled at the closing edge. The bench changes its inputs only at the falling clock edge. Each request lasts one cycle, with `req_vld` dropped before the next rising edge. The bench also moves `stat_next` to a different value right after each status read, so a late sample would be visible.

// File: rtl/strb_pkg.sv
package strb_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RACK = 2'd1,
        S_WACK = 2'd2
    } rsp_state_t;
endpackage

// File: rtl/strb_decode.sv
module strb_decode #(
    parameter int AW        = 4,
    parameter int STAT_ADDR = 0,
    parameter int CTL_ADDR  = 1
) (
    input  logic          rst,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    output logic          stat_hit,
    output logic          ctl_hit
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] CTL_A  = AW'(CTL_ADDR);

    // the status field is read-only to software: writes do not decode
    always_comb begin
        stat_hit = !rst && req_vld && !req_wr && (req_addr == STAT_A);
        ctl_hit  = !rst && req_vld && (req_addr == CTL_A);
    end
endmodule

// File: rtl/strb_strobes.sv
module strb_strobes #(
    parameter bit ACC_EN  = 1'b0,
    parameter bit MOD_EN  = 1'b0,
    parameter bit RD_EN   = 1'b0,
    parameter bit WR_EN   = 1'b0,
    parameter bit RD_SIDE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic is_wr,
    output logic acc,
    output logic mod,
    output logic rd,
    output logic wr
);
    logic rd_c, wr_c, mod_c;

    always_comb begin
        rd_c  = hit && !is_wr;
        wr_c  = hit && is_wr;
        mod_c = wr_c || (RD_SIDE && rd_c);
    end

    generate
        if (ACC_EN) begin : g_acc
            assign acc = hit;
        end else begin : g_no_acc
            assign acc = 1'b0;
        end
        if (MOD_EN) begin : g_mod
            assign mod = mod_c;
        end else begin : g_no_mod
            assign mod = 1'b0;
        end
        if (RD_EN) begin : g_rd
            assign rd = rd_c;
        end else begin : g_no_rd
            assign rd = 1'b0;
        end
        if (WR_EN) begin : g_wr
            assign wr = wr_c;
        end else begin : g_no_wr
            assign wr = 1'b0;
        end
    endgenerate

    // R5: read and write strobes of one field never coincide
    p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));
    // R1: no strobe is raised while reset is held
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst |-> !(acc || mod || rd || wr));
endmodule

// File: rtl/strb_ctl_reg.sv
module strb_ctl_reg #(
    parameter int         DW      = 8,
    parameter int         RST_VAL = 20,
    parameter bit         RCLR    = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          is_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value
);
    localparam logic [DW-1:0] RST_V = DW'(RST_VAL);

    always_ff @(posedge clk) begin
        if (rst)
            value <= RST_V;
        else if (hit && is_wr)
            value <= wdata;
        else if (hit && RCLR)
            value <= '0;
    end

    // R4: a write lands on the next cycle
    p_wr_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && is_wr) |=> (value == $past(wdata)));
    // R10: the value moves only when the field is addressed
    p_hold_unaddressed_r10: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(value));
    // R8: a read under read-clear empties the field
    p_rclr_r8: assert property (@(posedge clk) disable iff (rst)
        (RCLR && hit && !is_wr) |=> (value == '0));
endmodule

// File: rtl/strb_resp.sv
module strb_resp
    import strb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic          stat_hit,
    input  logic          ctl_hit,
    input  logic [DW-1:0] stat_next,
    input  logic [DW-1:0] ctl_value,
    output logic          rd_ack,
    output logic          wr_ack,
    output logic [DW-1:0] rdata
);
    rsp_state_t state, state_nx;
    logic [DW-1:0] rdata_nx;

    always_comb begin
        if (rst || !req_vld)
            state_nx = S_IDLE;
        else if (req_wr)
            state_nx = S_WACK;
        else
            state_nx = S_RACK;
    end

    always_comb begin
        if (stat_hit)
            rdata_nx = stat_next;
        else if (ctl_hit && !req_wr)
            rdata_nx = ctl_value;
        else
            rdata_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rdata <= '0;
        end else begin
            state <= state_nx;
            rdata <= rdata_nx;
        end
    end

    always_comb begin
        rd_ack = 1'b0;
        wr_ack = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RACK: rd_ack = 1'b1;
            S_WACK: wr_ack = 1'b1;
            default: ;
        endcase
    end

    // R2: each request kind receives its own acknowledge one cycle later
    p_rd_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_wr) |=> (rd_ack && !wr_ack));
    p_wr_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_wr) |=> (wr_ack && !rd_ack));
    // R3: status read returns the value present in the request cycle
    p_stat_data_r3: assert property (@(posedge clk) disable iff (rst)
        stat_hit |=> (rdata == $past(stat_next)));
    // R9: undecoded reads return zero
    p_undec_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_wr && !stat_hit && !ctl_hit) |=> (rdata == '0));
endmodule

// File: rtl/strobe_regblk.sv
module strobe_regblk #(
    parameter int AW          = 4,
    parameter int DW          = 8,
    parameter int STAT_ADDR   = 0,
    parameter int CTL_ADDR    = 1,
    parameter int CTL_RST     = 20,
    parameter bit CTL_RCLR    = 1'b0,
    parameter bit STAT_ACC_EN = 1'b0,
    parameter bit STAT_RD_EN  = 1'b0,
    parameter bit CTL_ACC_EN  = 1'b0,
    parameter bit CTL_MOD_EN  = 1'b0,
    parameter bit CTL_RD_EN   = 1'b0,
    parameter bit CTL_WR_EN   = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_ack,
    output logic          wr_ack,
    output logic [DW-1:0] rsp_rdata,
    input  logic [DW-1:0] stat_next,
    output logic          stat_acc,
    output logic          stat_mod,
    output logic          stat_rd_acc,
    output logic          stat_wr_acc,
    output logic [DW-1:0] ctl_value,
    output logic          ctl_acc,
    output logic          ctl_mod,
    output logic          ctl_rd_acc,
    output logic          ctl_wr_acc
);
    logic stat_hit, ctl_hit;

    strb_decode #(.AW(AW), .STAT_ADDR(STAT_ADDR), .CTL_ADDR(CTL_ADDR)) u_dec (
        .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .stat_hit(stat_hit), .ctl_hit(ctl_hit)
    );

    // status field has no software write path and no read side effect
    strb_strobes #(.ACC_EN(STAT_ACC_EN), .MOD_EN(1'b0), .RD_EN(STAT_RD_EN),
                   .WR_EN(1'b0), .RD_SIDE(1'b0)) u_stat_stb (
        .clk(clk), .rst(rst), .hit(stat_hit), .is_wr(req_wr),
        .acc(stat_acc), .mod(stat_mod), .rd(stat_rd_acc), .wr(stat_wr_acc)
    );

    strb_strobes #(.ACC_EN(CTL_ACC_EN), .MOD_EN(CTL_MOD_EN), .RD_EN(CTL_RD_EN),
                   .WR_EN(CTL_WR_EN), .RD_SIDE(CTL_RCLR)) u_ctl_stb (
        .clk(clk), .rst(rst), .hit(ctl_hit), .is_wr(req_wr),
        .acc(ctl_acc), .mod(ctl_mod), .rd(ctl_rd_acc), .wr(ctl_wr_acc)
    );

    strb_ctl_reg #(.DW(DW), .RST_VAL(CTL_RST), .RCLR(CTL_RCLR)) u_ctl (
        .clk(clk), .rst(rst), .hit(ctl_hit), .is_wr(req_wr),
        .wdata(req_wdata), .value(ctl_value)
    );

    strb_resp #(.DW(DW)) u_resp (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr),
        .stat_hit(stat_hit), .ctl_hit(ctl_hit), .stat_next(stat_next),
        .ctl_value(ctl_value), .rd_ack(rd_ack), .wr_ack(wr_ack), .rdata(rsp_rdata)
    );

    // R9: no strobe of either field on an address outside the map
    p_undec_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_addr != AW'(STAT_ADDR) && req_addr != AW'(CTL_ADDR))
        |-> !(stat_acc || stat_rd_acc || ctl_acc || ctl_mod || ctl_rd_acc || ctl_wr_acc));
    // R6: access strobe covers each read and write strobe
    p_acc_covers_r6: assert property (@(posedge clk) disable iff (rst)
        (CTL_ACC_EN && (ctl_rd_acc || ctl_wr_acc)) |-> ctl_acc);
endmodule

// File: tb/strobe_regblk_tb.sv
module strobe_regblk_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_vld = 1'b0, req_wr = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0, stat_next = '0;

    logic       a_rack, a_wack, a_sacc, a_smod, a_srd, a_swr, a_cacc, a_cmod, a_crd, a_cwr;
    logic [7:0] a_rdata, a_cval;
    logic       b_rack, b_wack, b_sacc, b_smod, b_srd, b_swr, b_cacc, b_cmod, b_crd, b_cwr;
    logic [7:0] b_rdata, b_cval;

    int nvec = 0, nerr = 0;
    bit done = 1'b0;

    // strobe and value snapshots taken in the request cycle and the cycle after
    logic [9:0] sa, sb, sa2;
    logic [7:0] va_before, va_after, vb_after, rd_a, rd_b;
    logic [1:0] ack_a;

    always #4 clk = ~clk;

    strobe_regblk #(.STAT_ACC_EN(1), .STAT_RD_EN(1), .CTL_ACC_EN(1), .CTL_MOD_EN(1),
                    .CTL_RD_EN(1), .CTL_WR_EN(1)) u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_ack(a_rack), .wr_ack(a_wack), .rsp_rdata(a_rdata),
        .stat_next(stat_next), .stat_acc(a_sacc), .stat_mod(a_smod), .stat_rd_acc(a_srd),
        .stat_wr_acc(a_swr), .ctl_value(a_cval), .ctl_acc(a_cacc), .ctl_mod(a_cmod),
        .ctl_rd_acc(a_crd), .ctl_wr_acc(a_cwr)
    );

    strobe_regblk #(.CTL_RCLR(1), .CTL_MOD_EN(1)) u_rc (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_ack(b_rack), .wr_ack(b_wack), .rsp_rdata(b_rdata),
        .stat_next(stat_next), .stat_acc(b_sacc), .stat_mod(b_smod), .stat_rd_acc(b_srd),
        .stat_wr_acc(b_swr), .ctl_value(b_cval), .ctl_acc(b_cacc), .ctl_mod(b_cmod),
        .ctl_rd_acc(b_crd), .ctl_wr_acc(b_cwr)
    );

    // strobe vector bit order: {sacc,smod,srd,swr,cacc,cmod,crd,cwr,rack,wack}
    function automatic logic [9:0] pack_a();
        return {a_sacc, a_smod, a_srd, a_swr, a_cacc, a_cmod, a_crd, a_cwr, a_rack, a_wack};
    endfunction
    function automatic logic [9:0] pack_b();
        return {b_sacc, b_smod, b_srd, b_swr, b_cacc, b_cmod, b_crd, b_cwr, b_rack, b_wack};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one-cycle request; strobes sampled mid request cycle, results mid next cycle
    task automatic xfer(input bit wr, input logic [3:0] a, input logic [7:0] d, input logic [7:0] nxt);
        @(negedge clk);
        req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; stat_next = nxt;
        #1;
        sa = pack_a(); sb = pack_b(); va_before = a_cval;
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0; stat_next = ~nxt;
        #1;
        sa2 = pack_a(); ack_a = {a_rack, a_wack};
        rd_a = a_rdata; rd_b = b_rdata; va_after = a_cval; vb_after = b_cval;
    endtask

    task automatic t_reset();
        chk("R1 ctl_value in reset", a_cval, 20);
        chk("R1 strobes/acks in reset", pack_a(), 0);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 ctl_value after reset", a_cval, 20);
        chk("R1 strobes/acks after reset", pack_a(), 0);
    endtask

    task automatic t_stat_read(input logic [7:0] v);
        xfer(1'b0, 4'd0, 8'h00, v);
        chk("R3 status read data", rd_a, v);
        chk("R3/R5/R6 strobes in read cycle", sa[9:2], 8'b1010_0000);
        chk("R3 strobe single cycle", sa2[9:2], 0);
        chk("R2 read ack", ack_a, 2'b10);
    endtask

    task automatic t_ctl_write(input logic [7:0] old, input logic [7:0] v);
        xfer(1'b1, 4'd1, v, 8'h11);
        chk("R4 old value during strobe", va_before, old);
        chk("R4/R5/R6/R7 strobes in write cycle", sa[9:2], 8'b0000_1101);
        chk("R4 new value next cycle", va_after, v);
        chk("R4 strobe gone next cycle", sa2[9:2], 0);
        chk("R2 write ack", ack_a, 2'b01);
    endtask

    task automatic t_ctl_read(input logic [7:0] v);
        xfer(1'b0, 4'd1, 8'hFF, 8'h22);
        chk("R12 ctl read data", rd_a, v);
        chk("R12/R7 strobes on ctl read", sa[9:2], 8'b0000_1010);
        chk("R12 value kept after read", va_after, v);
    endtask

    task automatic t_undecoded(input logic [7:0] cur);
        xfer(1'b0, 4'd7, 8'h00, 8'h33);
        chk("R9 undecoded read data", rd_a, 0);
        chk("R9 no strobes on undecoded read", sa[9:2], 0);
        chk("R9 undecoded read acked", ack_a, 2'b10);
        xfer(1'b1, 4'hF, 8'h99, 8'h33);
        chk("R9 no strobes on undecoded write", sa[9:2], 0);
        chk("R9 undecoded write acked", ack_a, 2'b01);
        chk("R9 ctl untouched", va_after, cur);
    endtask

    task automatic t_stat_write(input logic [7:0] cur);
        xfer(1'b1, 4'd0, 8'h77, 8'h44);
        chk("R10 no strobes on status write", sa[9:2], 0);
        chk("R10 ctl untouched", va_after, cur);
        xfer(1'b0, 4'd0, 8'h00, 8'hC3);
        chk("R10 status still follows input", rd_a, 8'hC3);
    endtask

    task automatic t_rclr();
        xfer(1'b1, 4'd1, 8'h5A, 8'h00);
        chk("R7 mod on write (rclr instance)", sb[4], 1);
        chk("R11 disabled strobes stay 0 on write", {sb[9:5], sb[3:2]}, 0);
        xfer(1'b0, 4'd1, 8'h00, 8'h00);
        chk("R8 read-clear returns old value", rd_b, 8'h5A);
        chk("R7 mod on read-clear read", sb[4], 1);
        chk("R11 disabled strobes stay 0 on read", {sb[9:5], sb[3:2]}, 0);
        chk("R8 field cleared after read", vb_after, 0);
        xfer(1'b0, 4'd0, 8'h00, 8'h66);
        chk("R11 disabled status strobes", sb[9:6], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_stat_read(8'h10);
        t_stat_read(8'hA5);
        t_ctl_write(8'd20, 8'd21);
        t_ctl_read(8'd21);
        t_ctl_write(8'd21, 8'hE7);
        t_ctl_read(8'hE7);
        t_undecoded(8'hE7);
        t_stat_write(8'hE7);
        t_rclr();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            nvec++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule